// File: doc/BRIEF.md
# Coprocessor Data Bus Bridge

This block couples the 8-bit local data bus of a secondary processor to a shared 8-bit system data bus that follows the primary processor's cycle protocol. Address lines are shared directly between the two processors, so only data crosses the bridge. The secondary processor's active-low read and write strobes are qualified against the system cycle direction and the address-enable phase. Every access it makes therefore looks like an ordinary primary-protocol bus cycle.

On a qualified write, the bridge captures the local data and asserts the drive enable for the system bus. It does this only while the address-enable phase is high. On a qualified read, it asserts the drive enable for the local bus. Data coming back from the system bus passes through a latch gated by the 1 MHz system clock level: the latch follows the system bus while that clock is high and holds its value while it is low. The block works in a faster core clock domain. Bus levels are sampled there, and data and enable outputs are registered, so the pad-level tri-state buffers are built outside the block.

Top module: `cpb_bridge`

## Requirements
- R1: While `rst_n` is low, `sys_drive_en` and `cp_drive_en` are 0 and `cp_data_out` is 0x00.
- R2: A qualified write (`cp_wr_n`=0, `cp_rd_n`=1, `bus_rw_n`=0, `aec`=1) sampled at a clock edge makes `sys_drive_en` 1 after that edge, with `sys_data_out` equal to the sampled `cp_data_in`.
- R3: While `aec` is 0, no write drives the system bus: `sys_drive_en` is 0 after the edge.
- R4: A qualified read (`cp_rd_n`=0, `cp_wr_n`=1, `bus_rw_n`=1) sampled at an edge makes `cp_drive_en` 1 after that edge, whatever the level of `aec`.
- R5: When `phi_sys` is 1 at an edge, `cp_data_out` takes the `sys_data_in` value sampled at that edge.
- R6: When `phi_sys` is 0 at an edge, `cp_data_out` keeps its value.
- R7: With both strobes high (idle), both drive enables are 0 after the edge.
- R8: With both strobes low at the same time (conflict), both drive enables are 0 after the edge.
- R9: A strobe that disagrees with `bus_rw_n` enables no driver. A write strobe during `bus_rw_n`=1 leaves `sys_drive_en` at 0, and a read strobe during `bus_rw_n`=0 leaves `cp_drive_en` at 0.
- R10: `sys_drive_en` and `cp_drive_en` are never 1 together.
- R11: A low `rst_n` acts at once. Its release reaches the logic after `SYNC_STAGES` clock edges, and outputs stay in the reset state until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that samples all bus levels |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi_sys | input | 1 | 1 MHz system clock level; read latch transparent while high |
| aec | input | 1 | Address-enable phase; writes may drive only while high |
| bus_rw_n | input | 1 | System cycle direction, 1 = read, 0 = write |
| cp_rd_n | input | 1 | Secondary processor read strobe, active low |
| cp_wr_n | input | 1 | Secondary processor write strobe, active low |
| cp_data_in | input | 8 | Data from the local bus toward the system bus |
| sys_data_in | input | 8 | Data sensed on the system bus |
| sys_data_out | output | 8 | Data to place on the system bus |
| sys_drive_en | output | 1 | Tri-state enable for the system bus driver |
| cp_data_out | output | 8 | Latched read data toward the local bus |
| cp_drive_en | output | 1 | Tri-state enable for the local bus driver |

## Verification
Every result is one register stage behind its stimulus. Drive enables, write data and the latch output all change at the first rising edge that samples the inputs. The reset state appears as soon as `rst_n` falls, and normal operation resumes `SYNC_STAGES` edges after release. The bench changes inputs one nanosecond after a rising edge. It then waits for exactly one rising edge and reads the outputs one nanosecond later, so each check sees the value produced by that single edge. The latch-hold scenario spans several edges with `phi_sys` low and confirms the value holds after each one.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
  localparam int unsigned CPB_DATA_W = 8;

  typedef enum logic [1:0] {
    CYC_IDLE     = 2'd0,
    CYC_READ     = 2'd1,
    CYC_WRITE    = 2'd2,
    CYC_CONFLICT = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/cpb_rst_sync.sv
module cpb_rst_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/cpb_cycle_qual.sv
module cpb_cycle_qual
  import cpb_pkg::*;
(
  input  logic clk,
  input  logic rst_q_n,
  input  logic aec,
  input  logic bus_rw_n,
  input  logic cp_rd_n,
  input  logic cp_wr_n,
  output logic wr_take,
  output logic sys_en_q,
  output logic cp_en_q
);
  cyc_kind_e kind;
  logic      sys_en_d;
  logic      cp_en_d;

  always_comb begin
    unique case ({cp_rd_n, cp_wr_n})
      2'b11:   kind = CYC_IDLE;
      2'b01:   kind = CYC_READ;
      2'b10:   kind = CYC_WRITE;
      default: kind = CYC_CONFLICT;
    endcase
  end

  always_comb begin
    sys_en_d = 1'b0;
    cp_en_d  = 1'b0;
    case (kind)
      CYC_WRITE: sys_en_d = aec & ~bus_rw_n;
      CYC_READ:  cp_en_d  = bus_rw_n;
      default: begin
        sys_en_d = 1'b0;
        cp_en_d  = 1'b0;
      end
    endcase
  end

  assign wr_take = sys_en_d;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sys_en_q <= 1'b0;
      cp_en_q  <= 1'b0;
    end else begin
      sys_en_q <= sys_en_d;
      cp_en_q  <= cp_en_d;
    end
  end
endmodule

// File: rtl/cpb_write_path.sv
module cpb_write_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              capture_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] hold_d;
  logic [DATA_W-1:0] hold_q;

  always_comb begin
    hold_d = capture_en ? din : hold_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) hold_q <= '0;
    else          hold_q <= hold_d;
  end

  assign dout = hold_q;
endmodule

// File: rtl/cpb_read_latch.sv
module cpb_read_latch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              gate,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] lat_d;
  logic [DATA_W-1:0] lat_q;

  always_comb begin
    lat_d = gate ? din : lat_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) lat_q <= '0;
    else          lat_q <= lat_d;
  end

  assign q = lat_q;
endmodule

// File: rtl/cpb_bridge.sv
module cpb_bridge #(
  parameter int unsigned DATA_W      = cpb_pkg::CPB_DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi_sys,
  input  logic              aec,
  input  logic              bus_rw_n,
  input  logic              cp_rd_n,
  input  logic              cp_wr_n,
  input  logic [DATA_W-1:0] cp_data_in,
  input  logic [DATA_W-1:0] sys_data_in,
  output logic [DATA_W-1:0] sys_data_out,
  output logic              sys_drive_en,
  output logic [DATA_W-1:0] cp_data_out,
  output logic              cp_drive_en
);
  logic rst_q_n;
  logic wr_take;

  cpb_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cpb_cycle_qual u_qual (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .aec      (aec),
    .bus_rw_n (bus_rw_n),
    .cp_rd_n  (cp_rd_n),
    .cp_wr_n  (cp_wr_n),
    .wr_take  (wr_take),
    .sys_en_q (sys_drive_en),
    .cp_en_q  (cp_drive_en)
  );

  cpb_write_path #(.DATA_W(DATA_W)) u_wr (
    .clk        (clk),
    .rst_q_n    (rst_q_n),
    .capture_en (wr_take),
    .din        (cp_data_in),
    .dout       (sys_data_out)
  );

  cpb_read_latch #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .gate    (phi_sys),
    .din     (sys_data_in),
    .q       (cp_data_out)
  );
endmodule

// File: rtl/cpb_bridge_chk.sv
module cpb_bridge_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_q_n,
  input logic              phi_sys,
  input logic              aec,
  input logic              bus_rw_n,
  input logic              cp_rd_n,
  input logic              cp_wr_n,
  input logic [DATA_W-1:0] cp_data_in,
  input logic [DATA_W-1:0] sys_data_in,
  input logic [DATA_W-1:0] sys_data_out,
  input logic              sys_drive_en,
  input logic [DATA_W-1:0] cp_data_out,
  input logic              cp_drive_en
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |-> (!sys_drive_en && !cp_drive_en && cp_data_out == '0));

  p_write_drive_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!cp_wr_n && cp_rd_n && !bus_rw_n && aec) |=>
      (sys_drive_en && sys_data_out == $past(cp_data_in)));

  p_aec_gate_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !aec |=> !sys_drive_en);

  p_read_drive_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!cp_rd_n && cp_wr_n && bus_rw_n) |=> cp_drive_en);

  p_latch_follow_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    phi_sys |=> (cp_data_out == $past(sys_data_in)));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !phi_sys |=> $stable(cp_data_out));

  p_idle_off_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cp_rd_n && cp_wr_n) |=> (!sys_drive_en && !cp_drive_en));

  p_conflict_off_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!cp_rd_n && !cp_wr_n) |=> (!sys_drive_en && !cp_drive_en));

  p_dir_mismatch_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((!cp_wr_n && bus_rw_n) || (!cp_rd_n && !bus_rw_n)) |=>
      (!sys_drive_en && !cp_drive_en));

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_drive_en && cp_drive_en));

  p_held_in_reset_r11: assert property (@(posedge clk)
    !rst_q_n |-> (!sys_drive_en && !cp_drive_en));
endmodule

bind cpb_bridge cpb_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_q_n      (rst_q_n),
  .phi_sys      (phi_sys),
  .aec          (aec),
  .bus_rw_n     (bus_rw_n),
  .cp_rd_n      (cp_rd_n),
  .cp_wr_n      (cp_wr_n),
  .cp_data_in   (cp_data_in),
  .sys_data_in  (sys_data_in),
  .sys_data_out (sys_data_out),
  .sys_drive_en (sys_drive_en),
  .cp_data_out  (cp_data_out),
  .cp_drive_en  (cp_drive_en)
);

// File: tb/cpb_bridge_tb.sv
module cpb_bridge_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       phi_sys, aec, bus_rw_n, cp_rd_n, cp_wr_n;
  logic [7:0] cp_data_in, sys_data_in;
  logic [7:0] sys_data_out, cp_data_out;
  logic       sys_drive_en, cp_drive_en;
  int         n_run  = 0;
  int         n_fail = 0;
  bit         done   = 1'b0;

  always #10 clk = ~clk;

  cpb_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .phi_sys(phi_sys), .aec(aec),
    .bus_rw_n(bus_rw_n), .cp_rd_n(cp_rd_n), .cp_wr_n(cp_wr_n),
    .cp_data_in(cp_data_in), .sys_data_in(sys_data_in),
    .sys_data_out(sys_data_out), .sys_drive_en(sys_drive_en),
    .cp_data_out(cp_data_out), .cp_drive_en(cp_drive_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic rd_n, input logic wr_n, input logic rw_n,
                       input logic a, input logic phi);
    cp_rd_n = rd_n; cp_wr_n = wr_n; bus_rw_n = rw_n; aec = a; phi_sys = phi;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    sys_data_in = 8'hFF; cp_data_in = 8'h11;
    step(); step();
    check("R1 sys_drive_en", {7'd0, sys_drive_en}, 8'h00);
    check("R1 cp_drive_en",  {7'd0, cp_drive_en},  8'h00);
    check("R1 cp_data_out",  cp_data_out,          8'h00);
    rst_n = 1'b1;
    step();
    check("R11 held after first edge", {7'd0, cp_drive_en}, 8'h00);
    step();
    check("R11 held until sync done", {7'd0, cp_drive_en}, 8'h00);
    step();
    check("R11 active after release", {7'd0, cp_drive_en}, 8'h01);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step();
  endtask

  task automatic t_write();
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    cp_data_in = 8'h5A;
    step();
    check("R2 drive on",  {7'd0, sys_drive_en}, 8'h01);
    check("R2 data",      sys_data_out,         8'h5A);
    check("R10 exclusive", {7'd0, cp_drive_en}, 8'h00);
    cp_data_in = 8'hC3;
    step();
    check("R2 new data",  sys_data_out,         8'hC3);
  endtask

  task automatic t_write_noaec();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    cp_data_in = 8'h77;
    step();
    check("R3 no drive without aec", {7'd0, sys_drive_en}, 8'h00);
  endtask

  task automatic t_read();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    step();
    check("R4 read drive (aec low)", {7'd0, cp_drive_en},  8'h01);
    check("R10 exclusive",           {7'd0, sys_drive_en}, 8'h00);
    aec = 1'b1;
    step();
    check("R4 read drive (aec high)", {7'd0, cp_drive_en}, 8'h01);
  endtask

  task automatic t_latch();
    phi_sys = 1'b1; sys_data_in = 8'hA5;
    step();
    check("R5 follow", cp_data_out, 8'hA5);
    sys_data_in = 8'h96;
    step();
    check("R5 follow again", cp_data_out, 8'h96);
    phi_sys = 1'b0; sys_data_in = 8'h3C;
    step();
    check("R6 hold", cp_data_out, 8'h96);
    sys_data_in = 8'h0F;
    step();
    check("R6 hold second edge", cp_data_out, 8'h96);
    phi_sys = 1'b1;
    step();
    check("R5 reopen", cp_data_out, 8'h0F);
  endtask

  task automatic t_idle();
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    step();
    check("R7 idle sys", {7'd0, sys_drive_en}, 8'h00);
    check("R7 idle cp",  {7'd0, cp_drive_en},  8'h00);
  endtask

  task automatic t_conflict();
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step();
    check("R8 conflict sys (write dir)", {7'd0, sys_drive_en}, 8'h00);
    check("R8 conflict cp (write dir)",  {7'd0, cp_drive_en},  8'h00);
    bus_rw_n = 1'b1;
    step();
    check("R8 conflict cp (read dir)", {7'd0, cp_drive_en}, 8'h00);
  endtask

  task automatic t_mismatch();
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    step();
    check("R9 write strobe in read cycle", {7'd0, sys_drive_en}, 8'h00);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    step();
    check("R9 read strobe in write cycle", {7'd0, cp_drive_en}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_write();
    t_write_noaec();
    t_read();
    t_latch();
    t_idle();
    t_conflict();
    t_mismatch();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule